// File: doc/BRIEF.md
# Ordered Expected-Versus-Actual Reaction Checker

This block is a hardware scoreboard for one output interface of a design under test. A reference source pushes predicted results into a small pending queue. The design's observed results are presented on a second input. Each pending prediction carries its own age counter. The checker emits one verdict per event: pass, missing, unexpected or incorrect. It also keeps saturating counts of each verdict kind.

A mode input picks how observations are paired with predictions. In strict mode, only the oldest live prediction may be compared, so results must arrive in predicted order. In any-order mode, the observed value itself selects the oldest live prediction that holds an equal value. A prediction older than the timeout limit is never matched. It is reported as missing in the next cycle that carries no observation.

Top module: `rxn_scoreboard`

## Requirements
- R1: After synchronous reset the queue is empty, verdict_valid and overflow are 0, and all four counters read 0.
- R2: An observation in cycle t+1 .. t+LIMIT after a prediction pushed in cycle t, equal to the selected candidate, produces verdict_code 0 (pass) with verdict_data = the predicted value, valid in the cycle after the observation, and removes that entry.
- R3: A prediction pushed in cycle t and not consumed by the end of cycle t+LIMIT becomes expired. It produces verdict_code 1 (missing) with its predicted value in the first later cycle that has no observation and no older expired entry, and is then removed.
- R4: An observation arriving while no unexpired prediction is pending produces verdict_code 2 (unexpected) with verdict_data = the observed value, and leaves the queue unchanged.
- R5: An observation whose selected candidate differs from it produces verdict_code 3 (incorrect) with verdict_data = the candidate's predicted value, and removes that candidate.
- R6: With mode_any = 0 the only candidate is the oldest unexpired entry.
- R7: With mode_any = 1 the candidate is the oldest unexpired entry equal to the observation. If no entry is equal, the oldest unexpired entry is the candidate (verdict incorrect).
- R8: A push in a cycle that starts with DEPTH entries pending is dropped, and overflow is 1 in the following cycle only. A slot freed in that same cycle is not reused until the next cycle.
- R9: A prediction pushed in the same cycle as an observation is not visible to that observation.
- R10: Exactly one verdict is produced per cycle at most. An observation always yields a verdict in the next cycle and takes precedence over pending timeouts. Expired entries are reported oldest first.
- R11: The four counters (pass, missing, unexpected, incorrect) each count their verdicts and saturate at all ones. cnt_clr clears all four in the next cycle and wins over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_any | input | 1 | 0 = strict order, 1 = any-order matching |
| exp_valid | input | 1 | Push a predicted result |
| exp_data | input | DATA_W | Predicted result value |
| obs_valid | input | 1 | Observed result present |
| obs_data | input | DATA_W | Observed result value |
| cnt_clr | input | 1 | Synchronous clear of the verdict counters |
| verdict_valid | output | 1 | A verdict is reported this cycle |
| verdict_code | output | 2 | 0 pass, 1 missing, 2 unexpected, 3 incorrect |
| verdict_data | output | DATA_W | Predicted value, or the observed value for unexpected |
| overflow | output | 1 | One-cycle pulse: a push was dropped on a full queue |
| cnt_pass | output | CNT_W | Saturating pass count |
| cnt_missing | output | CNT_W | Saturating missing count |
| cnt_unexpected | output | CNT_W | Saturating unexpected count |
| cnt_incorrect | output | CNT_W | Saturating incorrect count |

## Verification
The bench builds the block with DATA_W = 8, DEPTH = 4, LIMIT = 6 and CNT_W = 4. A depth of four lets the bench fill the queue and drop a push within a few cycles. A 4-bit counter saturates after only 15 verdicts. With these values the bench sweeps every observation delay from 1 to LIMIT+2 in both modes, crossing the exact expiry boundary. It also applies all six arrival orders of three predictions in both modes. Directed runs cover a push that coincides with an observation, timeouts that an observation holds back, and a clear that coincides with an increment.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
  localparam int N_VERDICTS = 4;

  typedef enum logic [1:0] {
    VD_PASS       = 2'd0,
    VD_MISSING    = 2'd1,
    VD_UNEXPECTED = 2'd2,
    VD_INCORRECT  = 2'd3
  } verdict_e;
endpackage

// File: rtl/rxn_queue.sv
// Pending prediction store: compacting queue, index 0 is oldest.
// Every entry carries an age that saturates at LIMIT (expired).
module rxn_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int LIMIT  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  input  logic [$clog2(DEPTH)-1:0]   pop_idx,
  output logic [DEPTH-1:0]           ent_valid,
  output logic [DEPTH-1:0]           ent_expired,
  output logic [DATA_W-1:0]          ent_data [DEPTH],
  output logic                       full
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AGE_W = $clog2(LIMIT + 1);

  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [DATA_W-1:0] data_n  [DEPTH];
  logic [DATA_W-1:0] up_data [DEPTH];
  logic [AGE_W-1:0]  age_q   [DEPTH];
  logic [AGE_W-1:0]  age_n   [DEPTH];
  logic [AGE_W-1:0]  up_age  [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_mid, cnt_n;
  logic              push_ok;

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
    return (a == AGE_W'(LIMIT)) ? a : a + 1'b1;
  endfunction

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      if (g < DEPTH - 1) begin : g_mid
        assign up_data[g] = data_q[g+1];
        assign up_age[g]  = age_q[g+1];
      end else begin : g_top
        assign up_data[g] = data_q[g];
        assign up_age[g]  = age_q[g];
      end
      assign ent_valid[g]   = cnt_q > CNT_W'(g);
      assign ent_expired[g] = ent_valid[g] && (age_q[g] == AGE_W'(LIMIT));
      assign ent_data[g]    = data_q[g];
    end
  endgenerate

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;

  always_comb begin
    cnt_mid = cnt_q - CNT_W'(pop);
    cnt_n   = cnt_mid + CNT_W'(push_ok);
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && (IDX_W'(i) >= pop_idx)) begin
        data_n[i] = up_data[i];
        age_n[i]  = bump(up_age[i]);
      end else begin
        data_n[i] = data_q[i];
        age_n[i]  = bump(age_q[i]);
      end
      if (push_ok && (CNT_W'(i) == cnt_mid)) begin
        data_n[i] = push_data;
        age_n[i]  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= data_n[i];
        age_q[i]  <= age_n[i];
      end
    end
  end
endmodule

// File: rtl/rxn_arbiter.sv
// Picks the candidate for an observation, or the oldest expired entry.
module rxn_arbiter #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic [DEPTH-1:0]         ent_valid,
  input  logic [DEPTH-1:0]         ent_expired,
  input  logic [DATA_W-1:0]        ent_data [DEPTH],
  input  logic                     obs_valid,
  input  logic [DATA_W-1:0]        obs_data,
  input  logic                     mode_any,
  output logic                     ev,
  output rxn_pkg::verdict_e        code,
  output logic [DATA_W-1:0]        vdata,
  output logic                     pop,
  output logic [$clog2(DEPTH)-1:0] pop_idx
);
  import rxn_pkg::*;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] live, hit;
  logic             has_live, has_hit, has_exp;
  logic [IDX_W-1:0] live_idx, hit_idx, exp_idx;

  always_comb begin
    live     = ent_valid & ~ent_expired;
    has_live = 1'b0; has_hit = 1'b0; has_exp = 1'b0;
    live_idx = '0;   hit_idx = '0;   exp_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      hit[i] = live[i] && (ent_data[i] == obs_data);
      if (live[i])        begin has_live = 1'b1; live_idx = IDX_W'(i); end
      if (hit[i])         begin has_hit  = 1'b1; hit_idx  = IDX_W'(i); end
      if (ent_expired[i]) begin has_exp  = 1'b1; exp_idx  = IDX_W'(i); end
    end

    ev = 1'b0; code = VD_PASS; vdata = obs_data; pop = 1'b0; pop_idx = '0;
    if (obs_valid) begin
      ev = 1'b1;
      if (!has_live) begin
        code = VD_UNEXPECTED;
      end else if (mode_any && has_hit) begin
        code = VD_PASS; pop = 1'b1; pop_idx = hit_idx;
        vdata = ent_data[hit_idx];
      end else begin
        pop = 1'b1; pop_idx = live_idx;
        vdata = ent_data[live_idx];
        code = (ent_data[live_idx] == obs_data) ? VD_PASS : VD_INCORRECT;
      end
    end else if (has_exp) begin
      ev = 1'b1; code = VD_MISSING; pop = 1'b1; pop_idx = exp_idx;
      vdata = ent_data[exp_idx];
    end
  end
endmodule

// File: rtl/rxn_tally.sv
// Saturating verdict counters with synchronous clear.
module rxn_tally #(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic [rxn_pkg::N_VERDICTS-1:0] inc,
  output logic [CNT_W-1:0]             cnt [rxn_pkg::N_VERDICTS]
);
  genvar g;
  generate
    for (g = 0; g < rxn_pkg::N_VERDICTS; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst || clr)                     cnt[g] <= '0;
        else if (inc[g] && (cnt[g] != '1))  cnt[g] <= cnt[g] + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rxn_scoreboard.sv
module rxn_scoreboard #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int LIMIT  = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_any,
  input  logic              exp_valid,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              obs_valid,
  input  logic [DATA_W-1:0] obs_data,
  input  logic              cnt_clr,
  output logic              verdict_valid,
  output logic [1:0]        verdict_code,
  output logic [DATA_W-1:0] verdict_data,
  output logic              overflow,
  output logic [CNT_W-1:0]  cnt_pass,
  output logic [CNT_W-1:0]  cnt_missing,
  output logic [CNT_W-1:0]  cnt_unexpected,
  output logic [CNT_W-1:0]  cnt_incorrect
);
  import rxn_pkg::*;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  ent_valid, ent_expired;
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic              full, ev, pop;
  logic [IDX_W-1:0]  pop_idx;
  verdict_e          code;
  logic [DATA_W-1:0] vdata;
  logic [N_VERDICTS-1:0] inc;
  logic [CNT_W-1:0]  cnt [N_VERDICTS];

  rxn_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LIMIT(LIMIT)) u_queue (
    .clk(clk), .rst(rst), .push(exp_valid), .push_data(exp_data),
    .pop(pop), .pop_idx(pop_idx), .ent_valid(ent_valid),
    .ent_expired(ent_expired), .ent_data(ent_data), .full(full)
  );

  rxn_arbiter #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arb (
    .ent_valid(ent_valid), .ent_expired(ent_expired), .ent_data(ent_data),
    .obs_valid(obs_valid), .obs_data(obs_data), .mode_any(mode_any),
    .ev(ev), .code(code), .vdata(vdata), .pop(pop), .pop_idx(pop_idx)
  );

  assign inc = ev ? (N_VERDICTS'(1) << code) : '0;

  rxn_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(inc), .cnt(cnt)
  );

  assign cnt_pass       = cnt[VD_PASS];
  assign cnt_missing    = cnt[VD_MISSING];
  assign cnt_unexpected = cnt[VD_UNEXPECTED];
  assign cnt_incorrect  = cnt[VD_INCORRECT];

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_valid <= 1'b0;
      verdict_code  <= 2'd0;
      verdict_data  <= '0;
      overflow      <= 1'b0;
    end else begin
      verdict_valid <= ev;
      verdict_code  <= code;
      verdict_data  <= vdata;
      overflow      <= exp_valid && full;
    end
  end
endmodule

// File: rtl/rxn_scoreboard_chk.sv
module rxn_scoreboard_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              exp_valid,
  input logic              obs_valid,
  input logic [DATA_W-1:0] obs_data,
  input logic              cnt_clr,
  input logic              verdict_valid,
  input logic [1:0]        verdict_code,
  input logic [DATA_W-1:0] verdict_data,
  input logic              overflow,
  input logic [CNT_W-1:0]  cnt_pass,
  input logic [CNT_W-1:0]  cnt_missing,
  input logic [CNT_W-1:0]  cnt_unexpected,
  input logic [CNT_W-1:0]  cnt_incorrect
);
  assert_ovf_needs_push_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(exp_valid));

  assert_obs_yields_verdict_R10: assert property (@(posedge clk) disable iff (rst)
    $past(obs_valid && !rst) |-> (verdict_valid && verdict_code != 2'd1));

  assert_missing_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict_code == 2'd1) |-> !$past(obs_valid));

  assert_unexp_echo_R4: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict_code == 2'd2) |-> (verdict_data == $past(obs_data)));

  assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt_pass == '0 && cnt_missing == '0 &&
                 cnt_unexpected == '0 && cnt_incorrect == '0));

  assert_pass_monotone_R11: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> (cnt_pass >= $past(cnt_pass)));
endmodule

bind rxn_scoreboard rxn_scoreboard_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .exp_valid(exp_valid), .obs_valid(obs_valid),
  .obs_data(obs_data), .cnt_clr(cnt_clr), .verdict_valid(verdict_valid),
  .verdict_code(verdict_code), .verdict_data(verdict_data), .overflow(overflow),
  .cnt_pass(cnt_pass), .cnt_missing(cnt_missing),
  .cnt_unexpected(cnt_unexpected), .cnt_incorrect(cnt_incorrect)
);

// File: tb/rxn_scoreboard_bench.sv
`timescale 1ns/1ps
module rxn_scoreboard_bench;
  localparam int DW  = 8;
  localparam int DEP = 4;
  localparam int LIM = 6;
  localparam int CW  = 4;
  localparam logic [1:0] C_PASS = 2'd0, C_MISS = 2'd1, C_UNEX = 2'd2, C_INC = 2'd3;

  logic clk = 1'b0, rst = 1'b1, mode_any = 1'b0;
  logic exp_valid = 1'b0, obs_valid = 1'b0, cnt_clr = 1'b0;
  logic [DW-1:0] exp_data = '0, obs_data = '0;
  logic verdict_valid, overflow;
  logic [1:0] verdict_code;
  logic [DW-1:0] verdict_data;
  logic [CW-1:0] cnt_pass, cnt_missing, cnt_unexpected, cnt_incorrect;

  int checks = 0, fails = 0;
  int tally [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  rxn_scoreboard #(.DATA_W(DW), .DEPTH(DEP), .LIMIT(LIM), .CNT_W(CW)) u_rxn_scoreboard (
    .clk(clk), .rst(rst), .mode_any(mode_any), .exp_valid(exp_valid),
    .exp_data(exp_data), .obs_valid(obs_valid), .obs_data(obs_data),
    .cnt_clr(cnt_clr), .verdict_valid(verdict_valid), .verdict_code(verdict_code),
    .verdict_data(verdict_data), .overflow(overflow), .cnt_pass(cnt_pass),
    .cnt_missing(cnt_missing), .cnt_unexpected(cnt_unexpected),
    .cnt_incorrect(cnt_incorrect)
  );

  task automatic chk_eq(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One clock: drive inputs, wait for the edge, sample at the next negedge.
  task automatic step(input logic pv, input logic [DW-1:0] pd,
                      input logic ov, input logic [DW-1:0] od,
                      input logic ev, input logic [1:0] ec,
                      input logic [DW-1:0] ed, input string tag);
    exp_valid = pv; exp_data = pd; obs_valid = ov; obs_data = od;
    @(negedge clk);
    exp_valid = 1'b0; obs_valid = 1'b0;
    checks++;
    if (verdict_valid !== ev || (ev && (verdict_code !== ec || verdict_data !== ed))) begin
      fails++;
      $display("FAIL %s actual v=%0b c=%0d d=%0h expected v=%0b c=%0d d=%0h",
               tag, verdict_valid, verdict_code, verdict_data, ev, ec, ed);
    end
    if (ev) tally[ec]++;
  endtask

  function automatic int sat(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic chk_counters(input string tag);
    chk_eq({tag, " pass"}, int'(cnt_pass),       sat(tally[0]));
    chk_eq({tag, " miss"}, int'(cnt_missing),    sat(tally[1]));
    chk_eq({tag, " unex"}, int'(cnt_unexpected), sat(tally[2]));
    chk_eq({tag, " inc"},  int'(cnt_incorrect),  sat(tally[3]));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v [3];
    for (int i = 0; i < 4; i++) tally[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk_eq("R1 verdict_valid", int'(verdict_valid), 0);
    chk_eq("R1 overflow", int'(overflow), 0);
    chk_counters("R1");
    step(0, 0, 1, 8'h55, 1, C_UNEX, 8'h55, "R1 R4 empty queue unexpected");

    // R2 R3 R4 R10: observation delay sweep across the expiry boundary
    for (int m = 0; m < 2; m++) begin
      mode_any = logic'(m);
      for (int d = 1; d <= LIM + 2; d++) begin
        logic [DW-1:0] val;
        val = DW'(16 * d + m + 1);
        step(1, val, 0, 0, 0, 0, 0, "R2 push");
        for (int k = 1; k <= LIM + 3; k++) begin
          logic e; logic [1:0] c;
          e = 0; c = C_PASS;
          if (d <= LIM) begin
            if (k == d) begin e = 1; c = C_PASS; end
          end else begin
            if (k == d) begin e = 1; c = C_UNEX; end
            else if (k == LIM + 1 && d != LIM + 1) begin e = 1; c = C_MISS; end
            else if (k == LIM + 2 && d == LIM + 1) begin e = 1; c = C_MISS; end
          end
          step(0, 0, logic'(k == d), val, e, c, val,
               $sformatf("R2 R3 R10 mode=%0d delay=%0d tick=%0d", m, d, k));
        end
      end
    end

    // R6 R7: all arrival orders of three predictions
    for (int m = 0; m < 2; m++) begin
      mode_any = logic'(m);
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++) begin
            int p [3];
            if (a == b || b == c || a == c) continue;
            p[0] = a; p[1] = b; p[2] = c;
            for (int i = 0; i < 3; i++) v[i] = DW'(8'hA0 + 16 * m + i);
            for (int i = 0; i < 3; i++) step(1, v[i], 0, 0, 0, 0, 0, "R6 R7 push");
            for (int j = 0; j < 3; j++) begin
              if (m == 1)
                step(0, 0, 1, v[p[j]], 1, C_PASS, v[p[j]],
                     $sformatf("R7 any-order %0d%0d%0d obs %0d", a, b, c, j));
              else
                step(0, 0, 1, v[p[j]], 1, (p[j] == j) ? C_PASS : C_INC, v[j],
                     $sformatf("R6 strict order %0d%0d%0d obs %0d", a, b, c, j));
            end
            step(0, 0, 0, 0, 0, 0, 0, "R6 R7 drained");
          end
    end

    // R5 R7: mismatch removes the oldest live entry
    mode_any = 1'b1;
    step(1, 8'h11, 0, 0, 0, 0, 0, "R5 push A");
    step(1, 8'h22, 0, 0, 0, 0, 0, "R5 push B");
    step(0, 0, 1, 8'h99, 1, C_INC, 8'h11, "R5 R7 no equal entry -> incorrect vs oldest");
    step(0, 0, 1, 8'h22, 1, C_PASS, 8'h22, "R5 R7 B still pending");
    step(0, 0, 1, 8'h11, 1, C_UNEX, 8'h11, "R5 A was removed");
    mode_any = 1'b0;
    step(1, 8'h33, 0, 0, 0, 0, 0, "R5 push A");
    step(1, 8'h44, 0, 0, 0, 0, 0, "R5 push B");
    step(0, 0, 1, 8'h44, 1, C_INC, 8'h33, "R5 R6 strict out-of-order -> incorrect");
    step(0, 0, 1, 8'h44, 1, C_PASS, 8'h44, "R5 R6 head now B");

    // R9: push and observation in the same cycle
    step(1, 8'h5A, 1, 8'h5A, 1, C_UNEX, 8'h5A, "R9 same-cycle push invisible");
    step(0, 0, 1, 8'h5A, 1, C_PASS, 8'h5A, "R9 visible next cycle");

    // R8: overflow and slot reuse
    for (int i = 0; i < DEP; i++) begin
      step(1, DW'(8'hC0 + i), 0, 0, 0, 0, 0, "R8 fill");
      chk_eq("R8 no overflow while filling", int'(overflow), 0);
    end
    step(1, 8'hC4, 0, 0, 0, 0, 0, "R8 push on full");
    chk_eq("R8 overflow on full push", int'(overflow), 1);
    step(1, 8'hC5, 1, 8'hC0, 1, C_PASS, 8'hC0, "R8 pop with push on full");
    chk_eq("R8 freed slot not reused same cycle", int'(overflow), 1);
    step(1, 8'hC6, 0, 0, 0, 0, 0, "R8 push after free");
    chk_eq("R8 overflow cleared", int'(overflow), 0);
    step(0, 0, 1, 8'hC1, 1, C_PASS, 8'hC1, "R8 drain 1");
    step(0, 0, 1, 8'hC2, 1, C_PASS, 8'hC2, "R8 drain 2");
    step(0, 0, 1, 8'hC3, 1, C_PASS, 8'hC3, "R8 drain 3");
    step(0, 0, 1, 8'hC6, 1, C_PASS, 8'hC6, "R8 accepted push after free");
    step(0, 0, 1, 8'hC4, 1, C_UNEX, 8'hC4, "R8 dropped push absent");

    // R10 R3: several expired entries, observation first, oldest timeout first
    for (int m = 0; m < 2; m++) begin
      mode_any = logic'(m);
      step(1, 8'hD1, 0, 0, 0, 0, 0, "R10 push A");
      step(1, 8'hD2, 0, 0, 0, 0, 0, "R10 push B");
      step(1, 8'hD3, 0, 0, 0, 0, 0, "R10 push C");
      for (int k = 3; k <= 6; k++) step(0, 0, 0, 0, 0, 0, 0, "R10 wait");
      if (m == 1) step(0, 0, 1, 8'hD3, 1, C_PASS, 8'hD3, "R10 R7 obs over expired A");
      else        step(0, 0, 1, 8'hD2, 1, C_PASS, 8'hD2, "R10 R6 obs over expired A");
      step(0, 0, 0, 0, 1, C_MISS, 8'hD1, "R10 R3 oldest expired first");
      step(0, 0, 0, 0, 1, C_MISS, (m == 1) ? 8'hD2 : 8'hD3, "R10 R3 next expired");
      step(0, 0, 0, 0, 0, 0, 0, "R10 queue drained");
    end

    // R11: counters, clear priority, saturation
    chk_counters("R11 totals");
    cnt_clr = 1'b1;
    step(0, 0, 1, 8'h01, 1, C_UNEX, 8'h01, "R11 clear with increment");
    cnt_clr = 1'b0;
    for (int i = 0; i < 4; i++) tally[i] = 0;
    chk_counters("R11 clear wins");
    for (int i = 0; i < 20; i++)
      step(0, 0, 1, DW'(i), 1, C_UNEX, DW'(i), "R11 R4 saturation run");
    chk_counters("R11 saturated");
    chk_eq("R11 unexpected saturates", int'(cnt_unexpected), 15);
    cnt_clr = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R11 clear");
    cnt_clr = 1'b0;
    for (int i = 0; i < 4; i++) tally[i] = 0;
    chk_counters("R11 cleared");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule